// File: doc/BRIEF.md
# Host Bridge Configuration Address Decoder

This block sits at the front of a host bridge. It watches a 32-bit processor bus and sorts every accepted access into one kind of outgoing request. An access can become a configuration request, an interrupt-acknowledge cycle, a boot ROM fetch, a dropped ROM write, an access to the indirect address register, a read of the bridge's own header, or a no-hit. The block takes configuration requests from two sources. The first is a 4 MiB memory-mapped window, in which the device is picked by a one-hot select field of address bits 11 to 21. A priority encoder turns that field into a compact device number. The second source is an indirect pair of I/O ports: an address register, and a data port that uses the stored address.

Each request is accepted with a valid/ready handshake. Exactly one decoded result comes out of a single output register for each request, in order. Configuration results carry the bus number, the device/function, the register offset and the byte size. The block also maps each device's four interrupt pins onto two shared lines, alternating the pins by device number. The configuration space itself, the interrupt controller and the ROM contents lie outside this block.

Top module: `hb_cfg_decoder`

## Requirements
- R1: A memory access with an address in 0x80800000 to 0x80BFFFFF gives kind 1 (config), with bus 0, register `addr[7:0]` and devfn `{device, addr[10:8]}`. The device number is the index (0 to 10) of the lowest set bit among `addr[11]` to `addr[21]`. Write data passes through unchanged (little-endian) and read data is 0.
- R2: In the window, if none of address bits 11 to 21 is set, the device number is 11.
- R3: An I/O write of size 2 (4 bytes) to 0xCF8 gives kind 5 and stores the byte-reversed write data as the indirect address. An I/O read of size 2 at 0xCF8 gives kind 5 and returns the stored value byte-reversed.
- R4: An I/O access to 0xCFC to 0xCFF while bit 31 of the stored address is set gives kind 1. Bus comes from stored bits 23:16, devfn from bits 15:8, and the register is `{stored[7:2], addr[1:0]}`. Write data is byte-reversed within its size: size 0 keeps byte 0, size 1 swaps the two low bytes, and size 2 reverses all four.
- R5: A data-port access while stored bit 31 is clear is a no-hit (kind 0).
- R6: A memory read of size 0 (1 byte) at 0xBFFFFFF0 gives kind 2 (interrupt acknowledge). A write there, or a larger read, is a no-hit.
- R7: A memory access at 0xFFF00000 or above gives kind 3 for reads and kind 4 (dropped) for writes. `out_rom_off` is the address minus 0xFFF00000; it is 0 for every other kind.
- R8: Any other access, and any access of size 3, is a no-hit. A no-hit read returns 0xFFFFFFFF and a no-hit write returns 0.
- R9: Interrupt pin p (0 to 3) of device d is input bit `4*d+p`. It drives line `(p+d) mod 2`. Each line is the registered OR of its pins and appears one cycle after the inputs.
- R10: `req_ready` is high when the output register is empty or `out_ready` is high. Each accepted request gives exactly one result, in order, and the result is held stable while `out_ready` is low.
- R11: A configuration read of bus 0, devfn 0 in dword 0x0C or 0x34 gives kind 6 (own header). The dword 0x0C holds 0x00001008 (cache line 0x08, latency 0x10, single function) and dword 0x34 holds 0. The data is the dword shifted right by 8 times `reg[1:0]` and masked to the size. Through the I/O port that result is then byte-reversed as in R4.
- R12: After reset `out_valid` is 0, the stored indirect address is 0 and both interrupt lines are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| req_io | input | 1 | 1 = I/O space, 0 = memory space |
| req_write | input | 1 | 1 = write |
| req_addr | input | 32 | Byte address |
| req_size | input | 2 | 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = invalid |
| req_wdata | input | 32 | Write data |
| out_valid | output | 1 | Decoded result present |
| out_ready | input | 1 | Result taken |
| out_kind | output | 3 | Result kind code (see requirements) |
| out_write | output | 1 | Copy of the request direction |
| out_size | output | 2 | Copy of the request size |
| out_bus | output | 8 | Configuration bus number |
| out_devfn | output | 8 | Configuration device/function |
| out_reg | output | 8 | Configuration register offset |
| out_data | output | 32 | Write data, read result or all ones |
| out_rom_off | output | 32 | Offset into the boot ROM |
| irq_pins | input | 4*NDEV | Device interrupt pins |
| irq_line | output | 2 | Swizzled interrupt lines |

## Verification
The hardest case to reach from the ports is the indirect data port acting on an address that an earlier access stored in byte-reversed form. The stimulus has to write 0xCF8 with the enable bit placed in the low byte of the bus data before any data-port access can become a configuration request. The bench also reads that path back through 0xCF8. Random runs keep rewriting the address register between data-port accesses, with the enable bit both set and clear. Backpressure is created by dropping `out_ready` while a second request waits, which holds the first result in place.

// File: rtl/hb_cfg_pkg.sv
package hb_cfg_pkg;

  typedef enum logic [2:0] {
    K_NOHIT   = 3'd0,
    K_CFG     = 3'd1,
    K_INTACK  = 3'd2,
    K_ROM     = 3'd3,
    K_ROMDROP = 3'd4,
    K_ADDRREG = 3'd5,
    K_SELF    = 3'd6
  } kind_e;

  typedef struct packed {
    kind_e       kind;
    logic [7:0]  bus;
    logic [7:0]  devfn;
    logic [7:0]  rg;
    logic [31:0] data;
    logic [31:0] rom_off;
    logic        areg_wr;
    logic [31:0] areg_val;
  } dec_t;

  // reverse byte order within the access size; smaller sizes zero the upper lanes
  function automatic logic [31:0] swap_by_size(input logic [31:0] v, input logic [1:0] sz);
    case (sz)
      2'd0:    return {24'b0, v[7:0]};
      2'd1:    return {16'b0, v[7:0], v[15:8]};
      default: return {v[7:0], v[15:8], v[23:16], v[31:24]};
    endcase
  endfunction

  function automatic logic [31:0] mask_by_size(input logic [31:0] v, input logic [1:0] sz);
    case (sz)
      2'd0:    return {24'b0, v[7:0]};
      2'd1:    return {16'b0, v[15:0]};
      default: return v;
    endcase
  endfunction

endpackage

// File: rtl/hb_idsel_encoder.sv
module hb_idsel_encoder #(
  parameter int N  = 11,
  parameter int IW = $clog2(N + 1)
) (
  input  logic [N-1:0]  sel,
  output logic [IW-1:0] idx
);
  // lowest set bit wins; no bit set gives N
  always_comb begin
    idx = IW'(N);
    for (int i = N - 1; i >= 0; i--) begin
      if (sel[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/hb_region_decode.sv
module hb_region_decode
  import hb_cfg_pkg::*;
#(
  parameter logic [31:0] WIN_BASE  = 32'h8080_0000,
  parameter int          WIN_BITS  = 22,
  parameter int          SEL_LO    = 11,
  parameter int          SEL_N     = 11,
  parameter logic [31:0] INTACK_AD = 32'hBFFF_FFF0,
  parameter int          ROM_BITS  = 20,
  parameter logic [31:0] PORT_ADDR = 32'h0000_0CF8,
  parameter logic [31:0] PORT_DATA = 32'h0000_0CFC
) (
  input  logic        io,
  input  logic        write,
  input  logic [31:0] addr,
  input  logic [1:0]  size,
  input  logic [31:0] wdata,
  input  logic [31:0] areg,
  output dec_t        dec
);
  localparam int IW = $clog2(SEL_N + 1);
  localparam int PADW = 8 - IW - 3;
  localparam logic [31:0] ROM_MASK = (32'h1 << ROM_BITS) - 32'h1;

  logic [IW-1:0] dev_idx;
  logic          size_ok;
  logic          via_port;
  logic          self_hit;
  logic [31:0]   self_val;

  hb_idsel_encoder #(.N(SEL_N), .IW(IW)) u_enc (
    .sel (addr[SEL_LO +: SEL_N]),
    .idx (dev_idx)
  );

  assign size_ok = (size != 2'd3);

  always_comb begin
    dec          = '0;
    dec.kind     = K_NOHIT;
    dec.data     = write ? 32'h0 : 32'hFFFF_FFFF;
    via_port     = 1'b0;
    self_hit     = 1'b0;
    self_val     = 32'h0;
    if (io) begin
      if (addr == PORT_ADDR && size == 2'd2) begin
        dec.kind = K_ADDRREG;
        if (write) begin
          dec.data     = 32'h0;
          dec.areg_wr  = 1'b1;
          dec.areg_val = swap_by_size(wdata, 2'd2);
        end else begin
          dec.data = swap_by_size(areg, 2'd2);
        end
      end else if (addr[31:2] == PORT_DATA[31:2] && size_ok && areg[31]) begin
        via_port  = 1'b1;
        dec.kind  = K_CFG;
        dec.bus   = areg[23:16];
        dec.devfn = areg[15:8];
        dec.rg    = {areg[7:2], addr[1:0]};
        dec.data  = write ? swap_by_size(wdata, size) : 32'h0;
      end
    end else if (size_ok) begin
      if (addr[31:WIN_BITS] == WIN_BASE[31:WIN_BITS]) begin
        dec.kind  = K_CFG;
        dec.bus   = 8'h00;
        dec.devfn = {{PADW{1'b0}}, dev_idx, addr[10:8]};
        dec.rg    = addr[7:0];
        dec.data  = write ? wdata : 32'h0;
      end else if (addr == INTACK_AD) begin
        if (!write && size == 2'd0) begin
          dec.kind = K_INTACK;
          dec.data = 32'h0;
        end
      end else if (&addr[31:ROM_BITS]) begin
        dec.kind    = write ? K_ROMDROP : K_ROM;
        dec.data    = 32'h0;
        dec.rom_off = addr & ROM_MASK;
      end
    end
    // the bridge answers reads of its own header dwords locally
    if (dec.kind == K_CFG && !write && dec.bus == 8'h00 && dec.devfn == 8'h00 &&
        (dec.rg[7:2] == 6'h03 || dec.rg[7:2] == 6'h0D)) begin
      self_hit = 1'b1;
      self_val = (dec.rg[7:2] == 6'h03) ? 32'h0000_1008 : 32'h0;
      self_val = mask_by_size(self_val >> {dec.rg[1:0], 3'b000}, size);
      dec.kind = K_SELF;
      dec.data = via_port ? swap_by_size(self_val, size) : self_val;
    end
  end
endmodule

// File: rtl/hb_irq_swizzle.sv
module hb_irq_swizzle #(
  parameter int NDEV = 4,
  parameter int NPIN = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NDEV*NPIN-1:0] pins,
  output logic [1:0]           lines
);
  logic [NDEV*NPIN-1:0] to_even;

  genvar d, p;
  generate
    for (d = 0; d < NDEV; d++) begin : g_dev
      for (p = 0; p < NPIN; p++) begin : g_pin
        assign to_even[d*NPIN+p] = (((p + d) % 2) == 0) ? pins[d*NPIN+p] : 1'b0;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) lines <= 2'b00;
    else     lines <= {|(pins & ~to_even), |to_even};
  end
endmodule

// File: rtl/hb_cfg_decoder.sv
module hb_cfg_decoder
  import hb_cfg_pkg::*;
#(
  parameter int NDEV = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_io,
  input  logic             req_write,
  input  logic [31:0]      req_addr,
  input  logic [1:0]       req_size,
  input  logic [31:0]      req_wdata,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [2:0]       out_kind,
  output logic             out_write,
  output logic [1:0]       out_size,
  output logic [7:0]       out_bus,
  output logic [7:0]       out_devfn,
  output logic [7:0]       out_reg,
  output logic [31:0]      out_data,
  output logic [31:0]      out_rom_off,
  input  logic [4*NDEV-1:0] irq_pins,
  output logic [1:0]       irq_line
);
  dec_t        dec;
  logic [31:0] areg;
  logic        accept;

  assign req_ready = !out_valid || out_ready;
  assign accept    = req_valid && req_ready;

  hb_region_decode u_dec (
    .io    (req_io),
    .write (req_write),
    .addr  (req_addr),
    .size  (req_size),
    .wdata (req_wdata),
    .areg  (areg),
    .dec   (dec)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      areg        <= 32'h0;
      out_kind    <= 3'd0;
      out_write   <= 1'b0;
      out_size    <= 2'd0;
      out_bus     <= 8'h0;
      out_devfn   <= 8'h0;
      out_reg     <= 8'h0;
      out_data    <= 32'h0;
      out_rom_off <= 32'h0;
    end else if (accept) begin
      out_valid   <= 1'b1;
      out_kind    <= dec.kind;
      out_write   <= req_write;
      out_size    <= req_size;
      out_bus     <= dec.bus;
      out_devfn   <= dec.devfn;
      out_reg     <= dec.rg;
      out_data    <= dec.data;
      out_rom_off <= dec.rom_off;
      if (dec.areg_wr) areg <= dec.areg_val;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  hb_irq_swizzle #(.NDEV(NDEV), .NPIN(4)) u_irq (
    .clk   (clk),
    .rst   (rst),
    .pins  (irq_pins),
    .lines (irq_line)
  );
endmodule

// File: rtl/hb_cfg_checker.sv
module hb_cfg_checker #(
  parameter int NDEV = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              out_valid,
  input logic              out_ready,
  input logic              req_ready,
  input logic [2:0]        out_kind,
  input logic              out_write,
  input logic [1:0]        out_size,
  input logic [31:0]       out_data,
  input logic [31:0]       out_rom_off,
  input logic [4*NDEV-1:0] irq_pins,
  input logic [1:0]        irq_line
);
  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_kind) && $stable(out_data));
  a_r10_ready: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |-> !req_ready);
  a_r8_ones: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_kind == 3'd0 && !out_write |-> out_data == 32'hFFFF_FFFF);
  a_r6_intack_read: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_kind == 3'd2 |-> !out_write && out_size == 2'd0);
  a_r7_drop_write: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_kind == 3'd4 |-> out_write);
  a_r7_off_zero: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_kind != 3'd3 && out_kind != 3'd4 |-> out_rom_off == 32'h0);
  a_r9_quiet: assert property (@(posedge clk) disable iff (rst)
    irq_pins == '0 |=> irq_line == 2'b00);
  a_r12_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !out_valid && irq_line == 2'b00);
endmodule

bind hb_cfg_decoder hb_cfg_checker #(.NDEV(NDEV)) u_chk (
  .clk(clk), .rst(rst), .out_valid(out_valid), .out_ready(out_ready),
  .req_ready(req_ready), .out_kind(out_kind), .out_write(out_write),
  .out_size(out_size), .out_data(out_data), .out_rom_off(out_rom_off),
  .irq_pins(irq_pins), .irq_line(irq_line)
);

// File: tb/test_hb_cfg_decoder.sv
module test_hb_cfg_decoder;
  localparam int NDEV = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 0, req_io = 0, req_write = 0, out_ready = 1;
  logic [31:0] req_addr = 0, req_wdata = 0;
  logic [1:0] req_size = 0;
  logic req_ready, out_valid, out_write;
  logic [2:0] out_kind;
  logic [1:0] out_size, irq_line;
  logic [7:0] out_bus, out_devfn, out_reg;
  logic [31:0] out_data, out_rom_off;
  logic [4*NDEV-1:0] irq_pins = '0;

  int checks = 0, errors = 0;
  logic [31:0] model_areg = 0;

  always #10 clk = ~clk;

  hb_cfg_decoder #(.NDEV(NDEV)) i_hb_cfg_decoder (.*);

  initial begin
    #4_000_000;
    errors++;
    $display("FAIL watchdog: run did not complete (actual hung, expected done)");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] rev(input logic [31:0] v, input logic [1:0] sz);
    if (sz == 0) return {24'b0, v[7:0]};
    if (sz == 1) return {16'b0, v[7:0], v[15:8]};
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction

  // expected result, written from the requirement text
  function automatic void model(input logic io, wr, input logic [31:0] a, input logic [1:0] sz,
      input logic [31:0] wd, input logic [31:0] ar,
      output logic [2:0] k, output logic [7:0] b, dv, rg,
      output logic [31:0] dat, rof, output logic awr, output logic [31:0] aval);
    int dev;
    logic port;
    logic [31:0] hdr;
    k = 0; b = 0; dv = 0; rg = 0; rof = 0; awr = 0; aval = 0; port = 0;
    dat = wr ? 32'h0 : 32'hFFFF_FFFF;
    if (io) begin
      if (a == 32'hCF8 && sz == 2) begin
        k = 5;
        if (wr) begin dat = 0; awr = 1; aval = rev(wd, 2); end
        else dat = rev(ar, 2);
      end else if (a >= 32'hCFC && a <= 32'hCFF && sz != 3 && ar[31]) begin
        k = 1; port = 1; b = ar[23:16]; dv = ar[15:8]; rg = {ar[7:2], a[1:0]};
        dat = wr ? rev(wd, sz) : 0;
      end
    end else if (sz != 3) begin
      if (a >= 32'h8080_0000 && a <= 32'h80BF_FFFF) begin
        dev = 11;
        for (int i = 10; i >= 0; i--) if (a[11+i]) dev = i;
        k = 1; dv = 8'(dev * 8 + int'(a[10:8])); rg = a[7:0];
        dat = wr ? wd : 0;
      end else if (a == 32'hBFFF_FFF0) begin
        if (!wr && sz == 0) begin k = 2; dat = 0; end
      end else if (a >= 32'hFFF0_0000) begin
        k = wr ? 4 : 3; dat = 0; rof = a - 32'hFFF0_0000;
      end
    end
    if (k == 1 && !wr && b == 0 && dv == 0 && (rg[7:2] == 3 || rg[7:2] == 13)) begin
      hdr = (rg[7:2] == 3) ? 32'h0000_1008 : 0;
      hdr = hdr >> (8 * int'(rg[1:0]));
      if (sz == 0) hdr &= 32'hFF; else if (sz == 1) hdr &= 32'hFFFF;
      k = 6;
      dat = port ? rev(hdr, sz) : hdr;
    end
  endfunction

  task automatic send(input string tag, input logic io, wr, input logic [31:0] a,
                      input logic [1:0] sz, input logic [31:0] wd);
    logic [2:0] k; logic [7:0] b, dv, rg; logic [31:0] dat, rof, aval; logic awr;
    model(io, wr, a, sz, wd, model_areg, k, b, dv, rg, dat, rof, awr, aval);
    @(negedge clk);
    req_valid = 1; req_io = io; req_write = wr; req_addr = a; req_size = sz; req_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    if (awr) model_areg = aval;
    chk({tag, " valid"}, 32'(out_valid), 1);
    chk({tag, " kind"}, 32'(out_kind), 32'(k));
    chk({tag, " data"}, out_data, dat);
    chk({tag, " rom_off"}, out_rom_off, rof);
    if (k == 1) begin
      chk({tag, " bus"}, 32'(out_bus), 32'(b));
      chk({tag, " devfn"}, 32'(out_devfn), 32'(dv));
      chk({tag, " reg"}, 32'(out_reg), 32'(rg));
    end
  endtask

  initial begin
    logic [31:0] a, wd;
    logic [1:0] lexp;
    int sel;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R12 out_valid after reset", 32'(out_valid), 0);
    chk("R12 irq_line after reset", 32'(irq_line), 0);
    rst = 0;
    @(negedge clk);
    chk("R12 req_ready idle", 32'(req_ready), 1);
    send("R12 address reg zero", 1, 0, 32'hCF8, 2, 0);

    send("R1 window dev0 fn5", 0, 1, 32'h8080_0D40, 2, 32'hDEAD_BEEF);
    send("R1 window dev10", 0, 0, 32'h80A0_0004, 1, 0);
    send("R1 window priority bits13,17", 0, 0, 32'h8082_2110, 2, 0);
    send("R2 window no select bit", 0, 0, 32'h8080_0710, 2, 0);
    send("R11 own header dword 0x0C", 0, 0, 32'h8080_080C, 2, 0);
    send("R11 own header latency byte", 0, 0, 32'h8080_080D, 0, 0);
    send("R11 own header 0x34", 0, 0, 32'h8080_0834, 2, 0);
    send("R3 address reg write", 1, 1, 32'hCF8, 2, 32'h0C_18_02_80);
    send("R3 address reg read", 1, 0, 32'hCF8, 2, 0);
    send("R4 data port write 4B", 1, 1, 32'hCFC, 2, 32'h1122_3344);
    send("R4 data port write 2B", 1, 1, 32'hCFE, 1, 32'h0000_ABCD);
    send("R3 address own header", 1, 1, 32'hCF8, 2, 32'h0C_00_00_80);
    send("R11 own header via port", 1, 0, 32'hCFC, 1, 0);
    send("R3 address disabled", 1, 1, 32'hCF8, 2, 32'h0C_18_02_00);
    send("R5 data port disabled", 1, 0, 32'hCFC, 2, 0);
    send("R6 intack read", 0, 0, 32'hBFFF_FFF0, 0, 0);
    send("R6 intack 2-byte", 0, 0, 32'hBFFF_FFF0, 1, 0);
    send("R6 intack write", 0, 1, 32'hBFFF_FFF0, 0, 5);
    send("R7 rom read", 0, 0, 32'hFFF1_2344, 2, 0);
    send("R7 rom write dropped", 0, 1, 32'hFFFF_FFFC, 2, 32'h55);
    send("R8 nohit read", 0, 0, 32'h1000_0000, 2, 0);
    send("R8 nohit write", 0, 1, 32'h80C0_0000, 2, 7);
    send("R8 size 3", 0, 0, 32'h8080_0800, 3, 0);

    // R10 backpressure: first result held while a second request waits
    @(negedge clk);
    out_ready = 0;
    req_valid = 1; req_io = 0; req_write = 0; req_addr = 32'hFFF0_0010; req_size = 2;
    @(posedge clk); @(negedge clk);
    req_addr = 32'h2000_0000;
    chk("R10 ready low when full", 32'(req_ready), 0);
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R10 held kind", 32'(out_kind), 3);
    chk("R10 held offset", out_rom_off, 32'h10);
    out_ready = 1;
    @(posedge clk); @(negedge clk);
    req_valid = 0;
    chk("R10 second result kind", 32'(out_kind), 0);
    chk("R10 second result data", out_data, 32'hFFFF_FFFF);
    @(posedge clk); @(negedge clk);
    chk("R10 drains", 32'(out_valid), 0);

    // R9 interrupt swizzle
    for (int t = 0; t < 40; t++) begin
      @(negedge clk);
      irq_pins = (t < 16) ? (16'h1 << t) : 16'($urandom);
      lexp = 0;
      for (int d = 0; d < NDEV; d++)
        for (int p = 0; p < 4; p++)
          if (irq_pins[4*d+p]) lexp[(p + d) % 2] = 1;
      @(posedge clk); @(negedge clk);
      chk("R9 irq lines", 32'(irq_line), 32'(lexp));
    end
    irq_pins = 0;

    // random mix across regions
    for (int n = 0; n < 400; n++) begin
      sel = $urandom_range(0, 7);
      wd = $urandom;
      case (sel)
        0, 1: a = 32'h8080_0000 | ($urandom & 32'h003F_FFFF);
        2: a = 32'h8080_0000 | ($urandom & 32'h0000_0FFF) | (32'h800 << $urandom_range(0, 10));
        3: a = 32'hCF8;
        4: a = 32'hCFC + $urandom_range(0, 3);
        5: a = 32'hFFF0_0000 | ($urandom & 32'h000F_FFFF);
        6: a = 32'hBFFF_FFF0;
        default: a = $urandom;
      endcase
      if (sel == 3 && $urandom_range(0, 1) == 1) wd[7] = ~wd[7];
      send("R1 random mix", (sel == 3 || sel == 4), 1'($urandom), a,
           2'($urandom_range(0, 3)), wd);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule